// File: doc/BRIEF.md
# USB Clock Request Timer

This block decides when a USB device core needs its 48 MHz clock running. It watches single-cycle pulses from the always-on domain: general bus activity, any change on the data lines, a packet sent or received, and a change of suspend state. From these it keeps one "clock needed" flag. Software can read the flag but cannot write it. When the flag rises, the block can also raise a one-cycle wake request for the power controller.

Timing in milliseconds comes from a one-cycle `tick_ms` strobe. An always-on counter outside the block produces this strobe. Any activity pulse raises the flag and starts a packet hold-off of `PKT_TICKS` ticks. A suspend-state change seen while the flag is up starts a second, shorter hold-off of `SUSP_TICKS` ticks. The flag drops as soon as either hold-off runs out. Both remaining counts are brought out as a status readout.

Top module: `usb_clkreq_timer`

## Requirements
- R1: During and right after reset, `clk_needed` and `wake_req` are 0, and both `pkt_left` and `susp_left` are 0.
- R2: A 1 on any of `act_pulse`, `line_chg` or `pkt_done` in a cycle sets `clk_needed` to 1 at the next clock edge. At that same edge `pkt_left` is loaded with `PKT_TICKS` (default 5).
- R3: Each `tick_ms` pulse that comes after the load reduces `pkt_left` by 1. A tick in the same cycle as the activity that loads the count is not counted. If no further activity arrives, `clk_needed` and `pkt_left` both become 0 at the edge that samples the `PKT_TICKS`-th such tick.
- R4: Any activity pulse while `clk_needed` is 1 reloads `pkt_left` to `PKT_TICKS`. The flag then clears `PKT_TICKS` ticks after that latest pulse.
- R5: A `susp_chg` pulse while `clk_needed` is 1 loads `susp_left` with `SUSP_TICKS` (default 2), restarting it if it is already running. `susp_left` then counts down one per tick. `clk_needed` clears at whichever of the two hold-offs runs out first, and both counts then read 0.
- R6: A `susp_chg` pulse while `clk_needed` is 0, with no activity pulse in the same cycle, has no effect: `clk_needed` stays 0 and `susp_left` stays 0.
- R7: Activity in the same cycle as an expiring tick keeps `clk_needed` at 1 and reloads `pkt_left` to `PKT_TICKS`. It raises no `wake_req`, and an expired suspend count reads 0. Activity after the flag has cleared sets it again one cycle later.
- R8: `wake_req` is 1 for exactly the one cycle in which `clk_needed` first reads 1 after a 0-to-1 change. It does so only if `wake_en` was 1 in the cycle of the activity pulse. `wake_req` never rises while the flag stays 1.
- R9: `pkt_left` is non-zero exactly when `clk_needed` is 1. Neither count ever exceeds its parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| act_pulse | input | 1 | Bus activity pulse |
| line_chg | input | 1 | Data line state change pulse |
| pkt_done | input | 1 | Packet received or transmitted pulse |
| susp_chg | input | 1 | Suspend state change pulse |
| wake_en | input | 1 | Enables a wake request on a rising flag |
| clk_needed | output | 1 | Clock needed flag (registered) |
| wake_req | output | 1 | One-cycle wake request (registered) |
| pkt_left | output | CW | Remaining packet hold-off ticks, 0 when idle |
| susp_left | output | CW | Remaining suspend hold-off ticks, 0 when idle |

## Verification
Two things can fall in the same cycle here: a new activity pulse and the expiring tick of one of the hold-offs. The bench provokes this by holding activity off until one count reads 1, then driving the activity pulse together with the final tick. It does this once through the packet count and once through the suspend count. The result counts as correct when the flag stays 1, `pkt_left` reads `PKT_TICKS`, the expired suspend count reads 0 and no wake pulse appears. A sweep over the gap between the activity pulse and the suspend change checks that the flag clears after min(`PKT_TICKS`, gap + `SUSP_TICKS`) ticks.

// File: rtl/usb_clkreq_pkg.sv
package usb_clkreq_pkg;
  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/usb_clkreq_hold.sv
module usb_clkreq_hold #(
  parameter int TICKS = 5,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic          clear,
  output logic [CW-1:0] cnt,
  output logic          last
);
  // Down-counter: load beats clear, clear beats a tick; 0 means idle.
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(TICKS);
    else if (clear)
      cnt <= '0;
    else if (tick && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/usb_clkreq_flag.sv
module usb_clkreq_flag (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic expire,
  input  logic wake_en,
  output logic flag,
  output logic flag_nxt,
  output logic wake_req
);
  // Activity always wins over an expiry in the same cycle.
  assign flag_nxt = act | (flag & ~expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      flag     <= flag_nxt;
      wake_req <= ~flag & flag_nxt & wake_en;
    end
  end
endmodule

// File: rtl/usb_clkreq_timer.sv
module usb_clkreq_timer
  import usb_clkreq_pkg::*;
#(
  parameter int PKT_TICKS  = 5,
  parameter int SUSP_TICKS = 2,
  localparam int CW = cnt_width(PKT_TICKS, SUSP_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          act_pulse,
  input  logic          line_chg,
  input  logic          pkt_done,
  input  logic          susp_chg,
  input  logic          wake_en,
  output logic          clk_needed,
  output logic          wake_req,
  output logic [CW-1:0] pkt_left,
  output logic [CW-1:0] susp_left
);
  logic act, expire, flag_nxt;
  logic pkt_last, susp_last;
  logic pkt_load, pkt_clr, susp_load, susp_clr;

  assign act    = act_pulse | line_chg | pkt_done;
  assign expire = clk_needed & tick_ms & (pkt_last | susp_last);

  assign pkt_load  = act;
  assign pkt_clr   = expire & ~act;
  assign susp_clr  = ~flag_nxt;
  assign susp_load = susp_chg & clk_needed & flag_nxt;

  usb_clkreq_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .expire   (expire),
    .wake_en  (wake_en),
    .flag     (clk_needed),
    .flag_nxt (flag_nxt),
    .wake_req (wake_req)
  );

  usb_clkreq_hold #(.TICKS(PKT_TICKS), .CW(CW)) u_pkt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_ms),
    .load  (pkt_load),
    .clear (pkt_clr),
    .cnt   (pkt_left),
    .last  (pkt_last)
  );

  usb_clkreq_hold #(.TICKS(SUSP_TICKS), .CW(CW)) u_susp (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_ms),
    .load  (susp_load),
    .clear (susp_clr),
    .cnt   (susp_left),
    .last  (susp_last)
  );
endmodule

// File: rtl/usb_clkreq_chk.sv
module usb_clkreq_chk
  import usb_clkreq_pkg::*;
#(
  parameter int PKT_TICKS  = 5,
  parameter int SUSP_TICKS = 2,
  localparam int CW = cnt_width(PKT_TICKS, SUSP_TICKS)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_ms,
  input logic          act_pulse,
  input logic          line_chg,
  input logic          pkt_done,
  input logic          susp_chg,
  input logic          wake_en,
  input logic          clk_needed,
  input logic          wake_req,
  input logic [CW-1:0] pkt_left,
  input logic [CW-1:0] susp_left
);
  logic any_act;
  assign any_act = act_pulse | line_chg | pkt_done;

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    any_act |=> (clk_needed && pkt_left == CW'(PKT_TICKS)));

  p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_needed) |-> $past(any_act));

  p_fall_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_needed) |-> $past(tick_ms));

  p_susp_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!clk_needed && !any_act) |=> (susp_left == '0 && !clk_needed));

  p_wake_edge_r8: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (clk_needed && !$past(clk_needed)));

  p_wake_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!clk_needed && any_act && !wake_en) |=> !wake_req);

  p_flag_count_r9: assert property (@(posedge clk) disable iff (rst)
    clk_needed == (pkt_left != '0));

  p_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (pkt_left <= CW'(PKT_TICKS)) && (susp_left <= CW'(SUSP_TICKS)));

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick_ms && !any_act && !susp_chg && clk_needed) |=> $stable(pkt_left));
endmodule

bind usb_clkreq_timer usb_clkreq_chk #(
  .PKT_TICKS(PKT_TICKS), .SUSP_TICKS(SUSP_TICKS)
) i_chk (.*);

// File: tb/test_usb_clkreq_timer.sv
module test_usb_clkreq_timer;
  localparam int PT = 5;
  localparam int ST = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 0, act_pulse = 0, line_chg = 0, pkt_done = 0, susp_chg = 0, wake_en = 0;
  logic clk_needed, wake_req;
  logic [CW-1:0] pkt_left, susp_left;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_clkreq_timer #(.PKT_TICKS(PT), .SUSP_TICKS(ST)) i_usb_clkreq_timer (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .act_pulse(act_pulse),
    .line_chg(line_chg), .pkt_done(pkt_done), .susp_chg(susp_chg),
    .wake_en(wake_en), .clk_needed(clk_needed), .wake_req(wake_req),
    .pkt_left(pkt_left), .susp_left(susp_left)
  );

  task automatic chk(input int actual, input int expected, input string tag);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // src: 0 act_pulse, 1 line_chg, 2 pkt_done, 3 none
  task automatic step(input int src, input bit t, input bit s, input bit w);
    @(negedge clk);
    act_pulse = (src == 0);
    line_chg  = (src == 1);
    pkt_done  = (src == 2);
    tick_ms = t; susp_chg = s; wake_en = w;
    @(posedge clk);
    #3;
    @(negedge clk);
    act_pulse = 0; line_chg = 0; pkt_done = 0; tick_ms = 0; susp_chg = 0; wake_en = 0;
    #2;
  endtask

  task automatic ticks_to_clear(output int n);
    n = 0;
    while (clk_needed && n < 20) begin
      step(3, 1, 0, 0);
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #3;
    chk(clk_needed, 0, "R1 flag in reset");
    chk(wake_req, 0, "R1 wake in reset");
    @(negedge clk); rst = 0;
    #2;
    chk(pkt_left, 0, "R1 pkt_left after reset");
    chk(susp_left, 0, "R1 susp_left after reset");

    // R2/R3: each source, with a tick-by-tick countdown
    for (int src = 0; src < 3; src++) begin
      step(src, 0, 0, 0);
      chk(clk_needed, 1, "R2 set by source");
      chk(pkt_left, PT, "R2 load");
      for (int j = 1; j <= PT; j++) begin
        step(3, 0, 0, 0);
        step(3, 1, 0, 0);
        chk(pkt_left, PT - j, "R3 countdown");
        chk(clk_needed, (j < PT) ? 1 : 0, "R3 flag vs ticks");
      end
    end

    // R3: tick in the load cycle is not counted
    step(0, 1, 0, 0);
    chk(pkt_left, PT, "R3 tick in load cycle");
    ticks_to_clear(n);
    chk(n, PT, "R3 ticks to clear");

    // R4: retrigger after k ticks
    for (int k = 0; k < PT; k++) begin
      step(2, 0, 0, 0);
      for (int j = 0; j < k; j++) step(3, 1, 0, 0);
      step(1, 0, 0, 0);
      chk(pkt_left, PT, "R4 reload");
      ticks_to_clear(n);
      chk(n, PT, "R4 clear after latest");
    end

    // R5/R6: sweep gap between activity and suspend change
    for (int g = 0; g <= PT + 1; g++) begin
      step(0, 0, 0, 0);
      for (int j = 0; j < g; j++) step(3, 1, 0, 0);
      step(3, 0, 1, 0);
      if (g < PT) begin
        chk(susp_left, ST, "R5 suspend load");
        ticks_to_clear(n);
        chk(g + n, (PT < g + ST) ? PT : g + ST, "R5 first expiry wins");
        chk(susp_left, 0, "R5 susp idle after clear");
      end else begin
        chk(clk_needed, 0, "R6 flag stays clear");
        chk(susp_left, 0, "R6 suspend ignored");
      end
    end

    // R5: suspend restart
    step(0, 0, 0, 0);
    step(3, 0, 1, 0);
    step(3, 1, 0, 0);
    step(3, 0, 1, 0);
    chk(susp_left, ST, "R5 suspend restart");
    ticks_to_clear(n);
    chk(n, ST, "R5 restart clear");

    // R7: activity with expiring packet tick
    step(0, 0, 0, 0);
    for (int j = 0; j < PT - 1; j++) step(3, 1, 0, 0);
    chk(pkt_left, 1, "R7 at last tick");
    step(1, 1, 0, 1);
    chk(clk_needed, 1, "R7 flag held");
    chk(pkt_left, PT, "R7 reload");
    chk(wake_req, 0, "R7 no wake");
    // R7: activity with expiring suspend tick
    step(3, 0, 1, 0);
    step(3, 1, 0, 0);
    step(2, 1, 0, 1);
    chk(clk_needed, 1, "R7 flag held susp");
    chk(susp_left, 0, "R7 susp expired");
    chk(pkt_left, PT, "R7 reload susp");
    chk(wake_req, 0, "R7 no wake susp");
    ticks_to_clear(n);
    step(0, 0, 0, 0);
    chk(clk_needed, 1, "R7 set again");
    ticks_to_clear(n);

    // R8: wake gating and single-cycle pulse
    for (int w = 0; w < 2; w++) begin
      step(w, 0, 0, w[0]);
      chk(wake_req, w, "R8 wake on rise");
      step(3, 0, 0, 1);
      chk(wake_req, 0, "R8 single cycle");
      step(2, 0, 0, 1);
      chk(wake_req, 0, "R8 no wake while set");
      chk(clk_needed == (pkt_left != 0), 1, "R9 flag matches count");
      ticks_to_clear(n);
      chk(pkt_left, 0, "R9 idle count");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule